// File: doc/BRIEF.md
# Session Request Pulser with Retry Lockout

This block holds the small set of software-visible control flags that a dual-role USB port needs around session start-up. When software sets the request bit, the block drives one data-line pulse toward a UTMI-style PHY. The pulse is timed in clock cycles and goes out on either the transmit-valid line or the termination-select line, depending on a method-select flag. Two role-swap enable flags are stored as plain read/write bits for software. A read-only bit shows whether the ID pin marks the port as the A side or the B side.

After a request is accepted, the block opens a retry window of six seconds. The window is counted by a millisecond prescaler derived from the clock-frequency parameter. While the window is open, further requests are dropped and a sticky rejected flag is raised. A rising edge on the B-side session-valid input during the window records a sticky event and closes the window at once. Software clears both sticky flags by writing ones to them.

Top module: `otg_srp_pulser`

## Requirements
- R1: After reset, with the ID pin high, the register reads 0x80000000 and both PHY pulse outputs are low.
- R2: A write with bit 3 set, sampled while no request is in progress, starts a pulse in the next cycle that stays high for exactly PULSE_CYCLES cycles. Bit 3 always reads 0.
- R3: Bit 2, taken from the accepting write, selects the pulse line: 0 drives the transmit-valid output and 1 drives the termination-select output. The other output stays low, so the two outputs are never high together.
- R4: Bits 1 (device-side role-swap enable) and 0 (host-side role-swap enable) are read/write flags that reset to 0. Bit 2 is also read/write.
- R5: Bit 31 is read-only and shows the ID pin as sampled on the previous clock: 0 for the A side and 1 for the B side.
- R6: Let W = FAIL_MS*CLK_HZ/1000. A request sampled 1 to W cycles after an accepted request starts no pulse, unless session-valid has ended the window. A request sampled W+1 cycles after is accepted.
- R7: A request that is dropped during the window or during the pulse sets sticky bit 9. Writing 1 to bit 9 clears it.
- R8: A rising edge on the session-valid input while the window is open sets sticky bit 8 within two cycles and ends the window. A request sampled two cycles after the edge is accepted. Writing 1 to bit 8 clears it.
- R9: A session-valid rising edge while no request is in progress leaves bit 8 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| id_pin_i | input | 1 | ID pin level (1 = B side) |
| sess_vld_i | input | 1 | B-side session-valid indication |
| rd_data_o | output | 32 | Register read value |
| phy_txvalid_o | output | 1 | PHY transmit-valid pulse output |
| phy_termsel_o | output | 1 | PHY termination-select pulse output |

## Verification
The bench builds the block with CLK_HZ = 4000, FAIL_MS = 20 and PULSE_CYCLES = 10. These values shrink the six-second window to 80 cycles and the pulse to 10 cycles. At this scale a run can reach both edges of the window exactly: a request one cycle before the window closes and a request on the first cycle after it. A full pulse on each line and an early end of the window through session-valid also fit in a short run. The enable and select flags and the ID-pin bit are driven with seeded random writes.

// File: rtl/otg_srp_pkg.sv
package otg_srp_pkg;
  localparam int unsigned BIT_HOST_EN = 0;
  localparam int unsigned BIT_DEV_EN  = 1;
  localparam int unsigned BIT_SEL     = 2;
  localparam int unsigned BIT_REQ     = 3;
  localparam int unsigned BIT_SV_EVT  = 8;
  localparam int unsigned BIT_REJ     = 9;
  localparam int unsigned BIT_MODE    = 31;
  localparam int unsigned TICKS_PER_S = 1000;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_WAIT  = 2'd2
  } srp_state_t;
endpackage

// File: rtl/otg_srp_regs.sv
module otg_srp_regs
  import otg_srp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  input  logic        id_pin_i,
  input  logic        busy_i,
  input  logic        sv_edge_i,
  output logic        start_o,
  output logic        sel_o,
  output logic [31:0] rd_data_o
);
  logic host_en_q, dev_en_q, sel_q, sv_evt_q, rej_q, mode_q;
  logic req_wr, reject;
  logic unused_bits;

  assign unused_bits = ^{wr_data_i[30:10], wr_data_i[7:4]};

  assign req_wr  = wr_en_i & wr_data_i[BIT_REQ];
  assign start_o = req_wr & ~busy_i;
  assign reject  = req_wr & busy_i;
  assign sel_o   = wr_data_i[BIT_SEL];

  always_ff @(posedge clk) begin
    if (rst) begin
      host_en_q <= 1'b0;
      dev_en_q  <= 1'b0;
      sel_q     <= 1'b0;
      sv_evt_q  <= 1'b0;
      rej_q     <= 1'b0;
      mode_q    <= 1'b1;
    end else begin
      mode_q <= id_pin_i;
      if (wr_en_i) begin
        host_en_q <= wr_data_i[BIT_HOST_EN];
        dev_en_q  <= wr_data_i[BIT_DEV_EN];
        sel_q     <= wr_data_i[BIT_SEL];
        if (wr_data_i[BIT_SV_EVT]) sv_evt_q <= 1'b0;
        if (wr_data_i[BIT_REJ])    rej_q    <= 1'b0;
      end
      // set wins over a clear in the same cycle
      if (sv_edge_i && busy_i) sv_evt_q <= 1'b1;
      if (reject)              rej_q    <= 1'b1;
    end
  end

  always_comb begin
    rd_data_o              = '0;
    rd_data_o[BIT_MODE]    = mode_q;
    rd_data_o[BIT_REJ]     = rej_q;
    rd_data_o[BIT_SV_EVT]  = sv_evt_q;
    rd_data_o[BIT_SEL]     = sel_q;
    rd_data_o[BIT_DEV_EN]  = dev_en_q;
    rd_data_o[BIT_HOST_EN] = host_en_q;
  end
endmodule

// File: rtl/otg_srp_timer.sv
module otg_srp_timer #(
  parameter int unsigned PRESC   = 60000,
  parameter int unsigned FAIL_MS = 6000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned PW = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam int unsigned MW = $clog2(FAIL_MS + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESC - 1);
  localparam logic [MW-1:0] MS_LAST  = MW'(FAIL_MS - 1);

  logic [PW-1:0] pre_q;
  logic [MW-1:0] ms_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (run_i) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        ms_q  <= ms_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign expire_o = run_i && (pre_q == PRE_LAST) && (ms_q == MS_LAST);
endmodule

// File: rtl/otg_srp_seq.sv
module otg_srp_seq
  import otg_srp_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 300000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic sel_i,
  input  logic expire_i,
  input  logic sv_edge_i,
  output logic busy_o,
  output logic txvalid_o,
  output logic termsel_o
);
  localparam int unsigned CW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_INIT = CW'(PULSE_CYCLES - 1);

  srp_state_t state_q;
  logic [CW-1:0] cnt_q;
  logic early_q;
  logic end_win;

  assign end_win = expire_i | sv_edge_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      early_q   <= 1'b0;
      txvalid_o <= 1'b0;
      termsel_o <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q   <= ST_PULSE;
            cnt_q     <= CNT_INIT;
            early_q   <= 1'b0;
            txvalid_o <= ~sel_i;
            termsel_o <= sel_i;
          end
        end
        ST_PULSE: begin
          if (end_win) early_q <= 1'b1;
          if (cnt_q == '0) begin
            txvalid_o <= 1'b0;
            termsel_o <= 1'b0;
            state_q   <= (early_q || end_win) ? ST_IDLE : ST_WAIT;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_WAIT: begin
          if (end_win) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/otg_srp_pulser.sv
module otg_srp_pulser
  import otg_srp_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 60000000,
  parameter int unsigned FAIL_MS      = 6000,
  parameter int unsigned PULSE_CYCLES = 300000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  input  logic        id_pin_i,
  input  logic        sess_vld_i,
  output logic [31:0] rd_data_o,
  output logic        phy_txvalid_o,
  output logic        phy_termsel_o
);
  localparam int unsigned PRESC = (CLK_HZ / TICKS_PER_S > 0) ? CLK_HZ / TICKS_PER_S : 1;

  logic sv_q1, sv_q2, sv_edge;
  logic busy, start, sel, expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      sv_q1 <= 1'b0;
      sv_q2 <= 1'b0;
    end else begin
      sv_q1 <= sess_vld_i;
      sv_q2 <= sv_q1;
    end
  end
  assign sv_edge = sv_q1 & ~sv_q2;

  otg_srp_regs u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .id_pin_i(id_pin_i), .busy_i(busy), .sv_edge_i(sv_edge),
    .start_o(start), .sel_o(sel), .rd_data_o(rd_data_o)
  );

  otg_srp_timer #(.PRESC(PRESC), .FAIL_MS(FAIL_MS)) u_timer (
    .clk(clk), .rst(rst), .clear_i(start), .run_i(busy), .expire_o(expire)
  );

  otg_srp_seq #(.PULSE_CYCLES(PULSE_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start_i(start), .sel_i(sel), .expire_i(expire),
    .sv_edge_i(sv_edge), .busy_o(busy), .txvalid_o(phy_txvalid_o),
    .termsel_o(phy_termsel_o)
  );
endmodule

// File: rtl/otg_srp_pulser_chk.sv
module otg_srp_pulser_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic        id_pin_i,
  input logic        sess_vld_i,
  input logic [31:0] rd_data_o,
  input logic        phy_txvalid_o,
  input logic        phy_termsel_o
);
  logic pulse;
  assign pulse = phy_txvalid_o | phy_termsel_o;

  p_one_drive_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({phy_txvalid_o, phy_termsel_o}));

  p_pulse_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> $past(wr_en_i && wr_data_i[3]));

  p_mode_follows_id_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rd_data_o[31] == $past(id_pin_i)));

  p_reject_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_data_i[3] && pulse) |=> rd_data_o[9]);

  p_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse) |=> !pulse);

  p_sv_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!sess_vld_i && !rd_data_o[8]) |=> !rd_data_o[8]);
endmodule

bind otg_srp_pulser otg_srp_pulser_chk u_chk (.*);

// File: tb/otg_srp_pulser_tb.sv
module otg_srp_pulser_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 4000;
  localparam int FAIL_MS = 20;
  localparam int PULSE_CYCLES = 10;
  localparam int WIN = FAIL_MS * CLK_HZ / 1000;

  logic clk = 1'b0;
  logic rst, wr_en, id_pin, sess_vld;
  logic [31:0] wr_data, rd_data;
  logic txv, tsel;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  otg_srp_pulser #(.CLK_HZ(CLK_HZ), .FAIL_MS(FAIL_MS), .PULSE_CYCLES(PULSE_CYCLES)) u_dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .id_pin_i(id_pin), .sess_vld_i(sess_vld), .rd_data_o(rd_data),
    .phy_txvalid_o(txv), .phy_termsel_o(tsel)
  );

  function automatic logic [31:0] exp_rd(logic [31:0] d, logic id, logic evt, logic rej);
    return {id, 21'b0, rej, evt, 5'b0, d[2:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic count_high(bit on_ts, output int n, output int other);
    n = 0;
    other = 0;
    while ((on_ts ? tsel : txv) && n < 1000) begin
      n++;
      if (on_ts ? txv : tsel) other++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n, other;
    logic [31:0] d;
    void'($urandom(32'd1234));
    rst = 1'b1; wr_en = 1'b0; wr_data = '0; id_pin = 1'b1; sess_vld = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset value", rd_data, 32'h8000_0000);
    chk("R1 outputs idle", {30'b0, txv, tsel}, 32'h0);

    // R4 / R5 seeded random writes of flags and ID pin
    for (int i = 0; i < 40; i++) begin
      id_pin = 1'($urandom_range(0, 1));
      d = $urandom & 32'hFFFF_FCF7;
      wr(d);
      chk("R4 R5 flags and mode", rd_data, exp_rd(d, id_pin, 1'b0, 1'b0));
      chk("R3 no pulse without request", {30'b0, txv, tsel}, 32'h0);
    end
    id_pin = 1'b1;
    wr(32'h0);

    // R2 pulse on transmit-valid, width
    wr(32'h0000_0008);
    chk("R2 request bit reads 0", {31'b0, rd_data[3]}, 32'h0);
    count_high(1'b0, n, other);
    chk("R2 pulse width", n, PULSE_CYCLES);
    chk("R3 termsel low during txvalid pulse", other, 0);

    // R6 edge of window: now at negedge after edge k+PULSE_CYCLES
    repeat (WIN - PULSE_CYCLES - 1) @(negedge clk);
    wr(32'h0000_0008);  // sampled at k+WIN
    chk("R6 request inside window ignored", {30'b0, txv, tsel}, 32'h0);
    chk("R7 reject flag set", {31'b0, rd_data[9]}, 32'h1);
    wr(32'h0000_0008);  // sampled at k+WIN+1
    chk("R6 request after window accepted", {30'b0, txv, tsel}, 32'h2);
    wr(32'h0000_0008);  // during pulse, dropped
    chk("R7 reject during pulse", {31'b0, rd_data[9]}, 32'h1);
    wr(32'h0000_0200);
    chk("R7 reject flag cleared", {31'b0, rd_data[9]}, 32'h0);
    count_high(1'b0, n, other);

    // R8 session-valid ends the window
    sess_vld = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 event flag set", {31'b0, rd_data[8]}, 32'h1);
    wr(32'h0000_000C);
    chk("R8 R3 request accepted on termsel", {30'b0, txv, tsel}, 32'h1);
    count_high(1'b1, n, other);
    chk("R3 termsel pulse width", n, PULSE_CYCLES);
    chk("R3 txvalid low during termsel pulse", other, 0);
    sess_vld = 1'b0;
    wr(32'h0000_0104);
    chk("R8 event flag cleared", {31'b0, rd_data[8]}, 32'h0);

    // R9 session-valid edge outside window
    repeat (WIN + 5) @(negedge clk);
    sess_vld = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 no event outside window", {31'b0, rd_data[8]}, 32'h0);
    sess_vld = 1'b0;
    chk("R4 select retained", {29'b0, rd_data[2:0]}, 32'h4);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule